// File: doc/BRIEF.md
# Dual-Bank Clock Divider with Pin-Selected Configuration

This block takes one fast source clock and produces six output clocks in two banks of three. Each bank has its own integer divider, so the two banks can run at unrelated fractions of the source. The three outputs of a bank are gated copies of one divided clock, so they stay low-skew. Odd divide values still give a near-50% duty cycle: a falling-edge flop stretches the high phase by half a source cycle.

A preloaded table holds eight configuration entries. Three select pins pick one entry. Each entry gives a divide value for each bank, a per-output enable mask for the pad drivers, and an output drive-strength bit. The select pins pass through a two-stage synchronizer. A bank takes its new divide value only at the end of its current output period, so a reselection cannot cut a pulse short.

An active-low power-down input serves as the asynchronous reset. While it is low, every output is low and every pad enable is off. When it is released, each bank starts a fresh period on the first rising source edge.

Top module: `clkbank_top`

## Requirements
- R1: While `pd_n` is low, `clk_out` and `out_en` are all zero.
- R2: The select input reaches the configuration through two source-clock flops. A change made between edges is reflected in `out_en`, `drive_hi` and `cfg_err` after the second following rising edge, and not before.
- R3: On release of `pd_n`, the synchronized select starts at all ones, so entry 7 governs until the pin value has passed through the synchronizer.
- R4: Entry i occupies `cfg_table[i*19 +: 19]`. Bits [5:0] hold the bank-A divide D, bits [11:6] hold the bank-B divide, bits [17:12] hold the output enables, and bit 18 holds the drive bit. A bank with a legal divide D produces a period of D source cycles whose high phase lasts D half-cycles (floor(D/2) cycles plus one half cycle when D is odd).
- R5: Bank A drives `clk_out[2:0]` and bank B drives `clk_out[5:3]`. Enabled outputs of one bank are identical at every instant.
- R6: `out_en[k]` equals enable bit k of the selected entry while powered. An output whose enable bit is 0 stays low.
- R7: A new divide value takes effect only at an output-period boundary. Every observed period is a complete period of either the old divide or the new one.
- R8: A divide field below 2 or above 63 is replaced by 63, and `cfg_err` is high while such an entry is selected.
- R9: `drive_hi` equals bit 18 of the selected entry.
- R10: After `pd_n` rises, outputs stay low until the first rising source edge. At that edge every enabled output goes high, which begins its first period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_src | input | 1 | Synthesized source clock |
| pd_n | input | 1 | Active-low power-down and asynchronous reset |
| cfg_sel | input | 3 | Configuration select pins |
| cfg_table | input | 152 | Eight preloaded 19-bit configuration entries |
| clk_out | output | 6 | Output clocks, bank A on [2:0], bank B on [5:3] |
| out_en | output | 6 | Per-output pad enables |
| drive_hi | output | 1 | Drive-strength setting of the selected entry |
| cfg_err | output | 1 | Selected entry holds an illegal divide value |

## Verification
The bench builds the block with its default parameters: a 3-bit select, 6-bit divide fields, a divide ceiling of 63 and three outputs per bank. With these values it reaches both ends of the legal range (2 and 63), odd and even divides, and the illegal value 0. The table also holds one entry with a partial enable mask and one with each drive setting. Outputs are sampled twice per source cycle, so period and high time are counted in half-cycles. The bench also switches between entries whose divides differ on both banks, which exercises the boundary-only reload.

// File: rtl/clkbank_pkg.sv
package clkbank_pkg;
  localparam int unsigned SEL_W_DEF   = 3;
  localparam int unsigned DIV_W_DEF   = 6;
  localparam int unsigned MAX_DIV_DEF = 63;
  localparam int unsigned OUTS_DEF    = 3;
  localparam int unsigned NUM_BANKS   = 2;

  // A divide value is usable when it lies in [2, maxd]
  function automatic bit div_is_legal(input int unsigned d, input int unsigned maxd);
    return (d >= 2) && (d <= maxd);
  endfunction

  // Illegal values fall back to the ceiling
  function automatic int unsigned div_sanitize(input int unsigned d, input int unsigned maxd);
    return div_is_legal(d, maxd) ? d : maxd;
  endfunction
endpackage

// File: rtl/clkbank_sel_sync.sv
module clkbank_sel_sync #(
  parameter int unsigned SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel_in,
  output logic [SEL_W-1:0] sel_s
);
  logic [SEL_W-1:0] sel_meta;
  logic [1:0]       age;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_meta <= '1;
      sel_s    <= '1;
    end else begin
      sel_meta <= sel_in;
      sel_s    <= sel_meta;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         age <= '0;
    else if (age != 2'd2) age <= age + 2'd1;
  end

  // R2: two-stage latency once two edges have passed since reset
  assert_sync_delay_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd2) |-> (sel_s == $past(sel_in, 2)));
endmodule

// File: rtl/clkbank_div.sv
module clkbank_div #(
  parameter int unsigned DIV_W   = 6,
  parameter int unsigned MAX_DIV = 63
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_in,
  output logic             div_clk
);
  logic             started;
  logic [DIV_W-1:0] cnt, div_q;
  logic             pos_q, neg_q;
  logic [DIV_W-1:0] cnt_nx, half_q;
  logic             period_end;

  assign cnt_nx     = cnt + 1'b1;
  assign half_q     = div_q >> 1;
  assign period_end = !started || (cnt == div_q - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      started <= 1'b0;
      cnt     <= '0;
      div_q   <= '0;
      pos_q   <= 1'b0;
    end else begin
      started <= 1'b1;
      if (period_end) begin
        div_q <= div_in;
        cnt   <= '0;
        pos_q <= 1'b1;
      end else begin
        cnt   <= cnt_nx;
        pos_q <= (cnt_nx < half_q);
      end
    end
  end

  // Half-cycle extension for odd divides
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) neg_q <= 1'b0;
    else        neg_q <= pos_q;
  end

  assign div_clk = pos_q | (neg_q & div_q[0]);

  // R4: counter stays inside the current period
  assert_cnt_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    started |-> (cnt < div_q));
  // R7: the divide register only moves at a period start
  assert_load_boundary_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (started && $past(started) && (div_q != $past(div_q))) |-> (cnt == '0));
  // R8: the divider never runs with an illegal value
  assert_div_legal_R8: assert property (@(posedge clk) disable iff (!rst_n)
    started |-> ((div_q >= 2) && (div_q <= MAX_DIV)));
  // R10: quiet before the first period starts
  assert_quiet_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !started |-> !div_clk);
endmodule

// File: rtl/clkbank_top.sv
module clkbank_top
  import clkbank_pkg::*;
#(
  parameter  int unsigned SEL_W   = SEL_W_DEF,
  parameter  int unsigned DIV_W   = DIV_W_DEF,
  parameter  int unsigned MAX_DIV = MAX_DIV_DEF,
  parameter  int unsigned OUTS    = OUTS_DEF,
  localparam int unsigned NCFG    = 1 << SEL_W,
  localparam int unsigned NOUT    = NUM_BANKS * OUTS,
  localparam int unsigned EW      = NUM_BANKS * DIV_W + NOUT + 1
) (
  input  logic               clk_src,
  input  logic               pd_n,
  input  logic [SEL_W-1:0]   cfg_sel,
  input  logic [NCFG*EW-1:0] cfg_table,
  output logic [NOUT-1:0]    clk_out,
  output logic [NOUT-1:0]    out_en,
  output logic               drive_hi,
  output logic               cfg_err
);
  logic [SEL_W-1:0]     sel_s;
  logic [EW-1:0]        entry;
  logic [NOUT-1:0]      en_field;
  logic [NUM_BANKS-1:0] bank_clk;
  logic [NUM_BANKS-1:0] bank_bad;

  clkbank_sel_sync #(.SEL_W(SEL_W)) u_sync (
    .clk(clk_src), .rst_n(pd_n), .sel_in(cfg_sel), .sel_s(sel_s)
  );

  assign entry    = cfg_table[sel_s*EW +: EW];
  assign en_field = entry[NUM_BANKS*DIV_W +: NOUT];
  assign drive_hi = entry[EW-1];
  assign cfg_err  = |bank_bad;
  assign out_en   = pd_n ? en_field : '0;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [DIV_W-1:0] raw_div, fix_div;
    assign raw_div     = entry[b*DIV_W +: DIV_W];
    assign bank_bad[b] = !div_is_legal(int'(raw_div), MAX_DIV);
    assign fix_div     = DIV_W'(div_sanitize(int'(raw_div), MAX_DIV));

    clkbank_div #(.DIV_W(DIV_W), .MAX_DIV(MAX_DIV)) u_div (
      .clk(clk_src), .rst_n(pd_n), .div_in(fix_div), .div_clk(bank_clk[b])
    );

    for (genvar o = 0; o < OUTS; o++) begin : g_out
      assign clk_out[b*OUTS+o] = bank_clk[b] & en_field[b*OUTS+o] & pd_n;
    end
  end
endmodule

// File: tb/sim_clkbank_top.sv
module sim_clkbank_top;
  localparam int EW = 19;
  localparam int WATCH_CYC = 150000;

  logic         clk_src = 1'b0;
  logic         pd_n;
  logic [2:0]   cfg_sel;
  logic [151:0] cfg_table;
  logic [5:0]   clk_out, out_en;
  logic         drive_hi, cfg_err;

  int errors = 0;
  int checks = 0;

  typedef struct { int bank; int div; string req; } exp_t;
  exp_t exp_q[$];

  always #4 clk_src = ~clk_src;

  clkbank_top u0 (
    .clk_src(clk_src), .pd_n(pd_n), .cfg_sel(cfg_sel), .cfg_table(cfg_table),
    .clk_out(clk_out), .out_en(out_en), .drive_hi(drive_hi), .cfg_err(cfg_err)
  );

  function automatic logic [EW-1:0] mk(int da, int db, logic [5:0] en, logic drv);
    return {drv, en, 6'(db), 6'(da)};
  endfunction

  task automatic check(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one sample per half source cycle, 2 ns after each edge
  task automatic half_sample(output logic [5:0] v);
    @(clk_src);
    #2;
    v = clk_out;
  endtask

  task automatic measure(int bank, output int hi, output int tot);
    logic [5:0] v;
    logic prev, cur;
    int n;
    hi = 0; tot = 0;
    half_sample(v); prev = v[bank*3];
    n = 0;
    while (n < 400) begin
      half_sample(v); cur = v[bank*3]; n++;
      if (!prev && cur) break;
      prev = cur;
    end
    hi = 1; tot = 1;
    while (n < 800) begin
      half_sample(v); n++;
      if (!v[bank*3]) break;
      hi++; tot++;
    end
    tot++;
    while (n < 1200) begin
      half_sample(v); n++;
      if (v[bank*3]) break;
      tot++;
    end
  endtask

  // driver side of the scoreboard
  task automatic expect_periods(int bank, int div, int n, string req);
    for (int i = 0; i < n; i++) exp_q.push_back('{bank, div, req});
  endtask

  // monitor side: pop each expectation and compare with a measured period
  task automatic drain();
    exp_t e;
    int hi, tot;
    while (exp_q.size() > 0) begin
      e = exp_q.pop_front();
      measure(e.bank, hi, tot);
      check(hi == e.div, {e.req, " high half-cycles"}, hi, e.div);
      check(tot == 2 * e.div, {e.req, " period half-cycles"}, tot, 2 * e.div);
    end
  endtask

  task automatic check_bank_match(int n, string req);
    logic [5:0] v;
    bit ok = 1;
    for (int i = 0; i < n; i++) begin
      half_sample(v);
      if (!((v[0] == v[1]) && (v[1] == v[2]) && (v[3] == v[4]) && (v[4] == v[5]))) ok = 0;
    end
    check(ok, req, 0, 1);
  endtask

  initial begin
    #(longint'(WATCH_CYC) * 8);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [5:0] v;
    int hi, tot;
    bit ok;
    cfg_table = '1;
    for (int i = 0; i < 8; i++) cfg_table[i*EW +: EW] = mk(8, 8, 6'b111111, 1'b0);
    cfg_table[7*EW +: EW] = mk(5, 4, 6'b111111, 1'b1);
    cfg_table[0*EW +: EW] = mk(2, 63, 6'b111111, 1'b0);
    cfg_table[1*EW +: EW] = mk(0, 3, 6'b101011, 1'b1);
    cfg_table[2*EW +: EW] = mk(6, 7, 6'b111111, 1'b0);
    pd_n = 1'b0;
    cfg_sel = 3'd0;
    repeat (5) @(posedge clk_src);
    #2;
    check(clk_out == 6'b0, "R1 outputs low in power-down", clk_out, 0);
    check(out_en == 6'b0, "R1 enables off in power-down", out_en, 0);

    // release 1 ns after a falling edge: next rising edge 3 ns later
    @(negedge clk_src); #1;
    pd_n = 1'b1;
    #1;
    check(clk_out == 6'b0, "R10 low before first rising edge", clk_out, 0);
    check(drive_hi == 1'b1, "R3 entry 7 governs after release", drive_hi, 1);
    @(posedge clk_src); #2;
    check(clk_out == 6'b111111, "R10 outputs rise at first edge", clk_out, 6'b111111);
    check(drive_hi == 1'b1, "R2 no change after one edge", drive_hi, 1);
    @(posedge clk_src); #2;
    check(drive_hi == 1'b0, "R2 new entry after two edges R9", drive_hi, 0);

    repeat (300) @(posedge clk_src);
    expect_periods(0, 2, 3, "R4 bank A even divide 2");
    expect_periods(1, 63, 2, "R4 bank B divide 63");
    drain();
    check(cfg_err == 1'b0, "R8 no error on legal entry", cfg_err, 0);
    check_bank_match(200, "R5 bank outputs identical");

    // entry 1: illegal bank-A divide, odd bank B, partial enables
    @(negedge clk_src); cfg_sel = 3'd1;
    repeat (300) @(posedge clk_src); #2;
    check(cfg_err == 1'b1, "R8 error flag on illegal divide", cfg_err, 1);
    check(out_en == 6'b101011, "R6 enables follow entry", out_en, 6'b101011);
    check(drive_hi == 1'b1, "R9 drive bit follows entry", drive_hi, 1);
    expect_periods(0, 63, 2, "R8 illegal divide runs as 63");
    expect_periods(1, 3, 3, "R4 bank B odd divide 3");
    drain();
    ok = 1;
    for (int i = 0; i < 300; i++) begin
      half_sample(v);
      if (v[2] || v[4]) ok = 0;
    end
    check(ok, "R6 disabled outputs stay low", 0, 1);

    // entry 2: reload at period boundary only
    @(negedge clk_src); cfg_sel = 3'd2;
    for (int i = 0; i < 3; i++) begin
      measure(0, hi, tot);
      check((hi == 63 && tot == 126) || (hi == 6 && tot == 12),
            "R7 bank A period whole old or new", tot, 12);
    end
    check(tot == 12, "R7 bank A settles on new divide", tot, 12);
    for (int i = 0; i < 3; i++) begin
      measure(1, hi, tot);
      check((hi == 3 && tot == 6) || (hi == 7 && tot == 14),
            "R7 bank B period whole old or new", tot, 14);
    end
    expect_periods(1, 7, 2, "R4 bank B odd divide 7");
    drain();

    @(negedge clk_src); #1;
    pd_n = 1'b0;
    #1;
    check(clk_out == 6'b0 && out_en == 6'b0, "R1 power-down forces low", clk_out, 0);
    repeat (3) @(posedge clk_src); #2;
    check(clk_out == 6'b0, "R1 stays low while held", clk_out, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule